// File: doc/BRIEF.md
# Refresh-Bounded Chip-Select Burst Splitter

This block sits between a host that asks for bursts of any length and the command sequencer of a self-refreshing pseudo-static memory. The memory refreshes itself only while chip select is high, so chip select must never stay low longer than the refresh interval. The block accepts a burst with a valid/ready handshake. It opens a transaction with a command-address phase and waits for the initial latency. It then moves one word per cycle. A counter tracks how long chip select has been low. When that count reaches the limit less a guard margin, the block closes the transaction after the current word. It holds chip select high for a programmable gap and reopens at the next word's address with the remaining length.

The limit comes from a two-bit temperature code, which is captured when a request is accepted. Code `01` is the cool setting and allows 4 µs. Every other code allows 1 µs, the conservative choice. Microseconds are turned into clock cycles with the `CLK_MHZ` parameter. On the last command-address cycle of each segment, the block samples the memory's strobe. A high strobe means a refresh is still running, and that segment then waits twice the normal latency.

Top module: `cs_burst_splitter`

## Requirements
- R1: `req_ready` is high only while the block is idle with chip select high. A request is taken on a cycle with `req_valid` and `req_ready` both high. Address, length, direction, wrap flag, temperature code and gap are captured on that cycle.
- R2: Temperature code 2'b01 sets a limit of 4*CLK_MHZ cycles. Codes 2'b00, 2'b10 and 2'b11 set CLK_MHZ cycles. Chip select never stays low for more than the limit minus GUARD cycles.
- R3: A segment ends after the word transferred in the cycle where chip select has been low for exactly limit minus GUARD cycles. With room for W words per segment, a burst of N words uses ceil(N/W) segments.
- R4: Between two segments of one burst, chip select stays high for max(captured gap, 1) cycles.
- R5: Each segment's command-address phase presents the start address plus the words already sent, the remaining word count, and the original direction and wrap flag.
- R6: Over the whole burst, `data_en` is high for exactly the requested number of cycles. `data_addr` runs from the start address upward by one per word.
- R7: Each segment begins with CA_CYC cycles of `ca_valid` with chip select low.
- R8: `rwds_in` is sampled on the last command-address cycle. If it is high, `lat_long` goes to 1 and 2*LAT_CYC latency cycles follow. If it is low, LAT_CYC cycles follow. The result is decided again for every segment.
- R9: `done` is a one-cycle pulse in the cycle after the final word, with chip select already high. A zero-length request gives `done` one cycle after acceptance and never lowers chip select.
- R10: After reset, chip select is high, `req_ready` is high, and `data_en` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Word start address |
| req_len | input | LEN_W | Number of words |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wrap | input | 1 | Wrapped burst type flag, passed through |
| cfg_temp_code | input | 2 | Temperature code that selects the limit |
| cfg_min_gap | input | GAP_W | Minimum chip-select-high cycles between segments |
| cs_n | output | 1 | Chip select, active low |
| ca_valid | output | 1 | Command-address phase in progress |
| ca_addr | output | ADDR_W | Segment start address |
| ca_len | output | LEN_W | Words remaining at segment start |
| ca_write | output | 1 | Segment direction |
| ca_wrap | output | 1 | Segment burst type |
| rwds_in | input | 1 | Memory strobe level during command-address |
| lat_long | output | 1 | Current segment uses doubled latency |
| data_en | output | 1 | One word moves this cycle |
| data_addr | output | ADDR_W | Address of the word moving this cycle |
| done | output | 1 | Whole burst finished |

## Verification
The bench drives bursts that fit exactly into one segment, and bursts one word longer, so that an off-by-one in the split compare shows up as an extra or missing segment or a low time of budget plus one. It runs every temperature code. A decoder that confused the two limits, or that gave codes 00 and 11 the long limit, would show a first-segment low time that is wrong by hundreds of cycles. A gap of zero checks that chip select still goes high for one cycle. The strobe is held high across multi-segment bursts to catch latency that is decided only once per burst. Continuation segments have their address and remaining length compared word by word, which catches a restart from the original address.

// File: rtl/cs_split_pkg.sv
package cs_split_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CA,
        ST_LAT,
        ST_DATA,
        ST_GAP
    } split_state_e;
endpackage

// File: rtl/cs_limit_sel.sv
module cs_limit_sel #(
    parameter int CLK_MHZ = 100,
    parameter int GUARD   = 4,
    parameter int CNT_W   = 9
) (
    input  logic [1:0]       temp_code,
    output logic [CNT_W-1:0] budget
);
    localparam int LIM_COOL = 4 * CLK_MHZ;
    localparam int LIM_HOT  = CLK_MHZ;

    always_comb begin
        if (temp_code == 2'b01) begin
            budget = CNT_W'(LIM_COOL - GUARD);
        end else begin
            budget = CNT_W'(LIM_HOT - GUARD);
        end
    end
endmodule

// File: rtl/cs_low_timer.sv
module cs_low_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_low,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        if (!cs_low) begin
            count_d = '0;
        end else if (count_q != '1) begin
            count_d = count_q + 1'b1;
        end else begin
            count_d = count_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/cs_burst_splitter.sv
module cs_burst_splitter
    import cs_split_pkg::*;
#(
    parameter int CLK_MHZ = 100,
    parameter int ADDR_W  = 24,
    parameter int LEN_W   = 12,
    parameter int GAP_W   = 4,
    parameter int GUARD   = 4,
    parameter int CA_CYC  = 3,
    parameter int LAT_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_write,
    input  logic              req_wrap,
    input  logic [1:0]        cfg_temp_code,
    input  logic [GAP_W-1:0]  cfg_min_gap,
    output logic              cs_n,
    output logic              ca_valid,
    output logic [ADDR_W-1:0] ca_addr,
    output logic [LEN_W-1:0]  ca_len,
    output logic              ca_write,
    output logic              ca_wrap,
    input  logic              rwds_in,
    output logic              lat_long,
    output logic              data_en,
    output logic [ADDR_W-1:0] data_addr,
    output logic              done
);
    localparam int CNT_W   = $clog2(4 * CLK_MHZ + 1);
    localparam int PH_A    = $clog2(2 * LAT_CYC + CA_CYC + 1);
    localparam int PH_B    = GAP_W + 1;
    localparam int PH_W    = (PH_A > PH_B) ? PH_A : PH_B;

    typedef struct packed {
        split_state_e      st;
        logic [ADDR_W-1:0] base;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  sent;
        logic              wr;
        logic              wrap;
        logic [1:0]        code;
        logic [GAP_W-1:0]  gap;
        logic [PH_W-1:0]   ph;
        logic              lat_long;
        logic              done;
    } split_regs_t;

    split_regs_t r_d, r_q;

    logic [CNT_W-1:0] budget;
    logic [CNT_W-1:0] low_cnt;
    logic             cs_low;
    logic [PH_W-1:0]  lat_len;

    cs_limit_sel #(
        .CLK_MHZ (CLK_MHZ),
        .GUARD   (GUARD),
        .CNT_W   (CNT_W)
    ) u_limit (
        .temp_code (r_q.code),
        .budget    (budget)
    );

    cs_low_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_low (cs_low),
        .count  (low_cnt)
    );

    assign cs_low  = (r_q.st == ST_CA) || (r_q.st == ST_LAT) || (r_q.st == ST_DATA);
    assign lat_len = r_q.lat_long ? PH_W'(2 * LAT_CYC) : PH_W'(LAT_CYC);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.base = req_addr;
                    r_d.len  = req_len;
                    r_d.sent = '0;
                    r_d.wr   = req_write;
                    r_d.wrap = req_wrap;
                    r_d.code = cfg_temp_code;
                    r_d.gap  = cfg_min_gap;
                    r_d.ph   = '0;
                    if (req_len == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st = ST_CA;
                    end
                end
            end
            ST_CA: begin
                if (r_q.ph == PH_W'(CA_CYC - 1)) begin
                    r_d.lat_long = rwds_in;
                    r_d.ph       = '0;
                    r_d.st       = ST_LAT;
                end else begin
                    r_d.ph = r_q.ph + 1'b1;
                end
            end
            ST_LAT: begin
                if (r_q.ph == lat_len - 1'b1) begin
                    r_d.ph = '0;
                    r_d.st = ST_DATA;
                end else begin
                    r_d.ph = r_q.ph + 1'b1;
                end
            end
            ST_DATA: begin
                r_d.sent = r_q.sent + 1'b1;
                if (r_q.sent + 1'b1 == r_q.len) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else if ({1'b0, low_cnt} + 1'b1 >= {1'b0, budget}) begin
                    r_d.ph = '0;
                    r_d.st = ST_GAP;
                end
            end
            ST_GAP: begin
                if (r_q.ph + 1'b1 >= PH_W'(r_q.gap)) begin
                    r_d.ph = '0;
                    r_d.st = ST_CA;
                end else begin
                    r_d.ph = r_q.ph + 1'b1;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign cs_n      = !cs_low;
    assign ca_valid  = (r_q.st == ST_CA);
    assign ca_addr   = r_q.base + ADDR_W'(r_q.sent);
    assign ca_len    = r_q.len - r_q.sent;
    assign ca_write  = r_q.wr;
    assign ca_wrap   = r_q.wrap;
    assign lat_long  = r_q.lat_long;
    assign data_en   = (r_q.st == ST_DATA);
    assign data_addr = r_q.base + ADDR_W'(r_q.sent);
    assign done      = r_q.done;
endmodule

// File: rtl/cs_burst_splitter_chk.sv
module cs_burst_splitter_chk #(
    parameter int CLK_MHZ = 100,
    parameter int GAP_W   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       cfg_temp_code,
    input logic [GAP_W-1:0] cfg_min_gap,
    input logic             cs_n,
    input logic             data_en,
    input logic             done
);
    localparam int W = $clog2(4 * CLK_MHZ + 2) + 1;

    logic [W-1:0]     lo_q, hi_q, lim_q;
    logic [GAP_W:0]   gmin_q;
    logic             prev_cs_n_q, mid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q        <= '0;
            hi_q        <= '0;
            lim_q       <= W'(CLK_MHZ);
            gmin_q      <= '0;
            prev_cs_n_q <= 1'b1;
            mid_q       <= 1'b0;
        end else begin
            prev_cs_n_q <= cs_n;
            if (req_valid && req_ready) begin
                lim_q  <= (cfg_temp_code == 2'b01) ? W'(4 * CLK_MHZ) : W'(CLK_MHZ);
                gmin_q <= (cfg_min_gap == '0) ? (GAP_W+1)'(1) : {1'b0, cfg_min_gap};
            end
            if (cs_n) begin
                lo_q <= '0;
                if (hi_q != '1) hi_q <= hi_q + 1'b1;
            end else begin
                hi_q <= '0;
                if (lo_q != '1) lo_q <= lo_q + 1'b1;
            end
            if (cs_n && !prev_cs_n_q) begin
                mid_q <= !done;
            end else if (!cs_n) begin
                mid_q <= 1'b0;
            end
        end
    end

    AST_CS_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> (lo_q < lim_q)); // R2
    AST_GAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_q && !cs_n) |-> (hi_q >= W'(gmin_q))); // R4
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> cs_n); // R1
    AST_DATA_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        data_en |-> !cs_n); // R6
    AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
endmodule

bind cs_burst_splitter cs_burst_splitter_chk #(
    .CLK_MHZ (CLK_MHZ),
    .GAP_W   (GAP_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .cfg_temp_code (cfg_temp_code),
    .cfg_min_gap   (cfg_min_gap),
    .cs_n          (cs_n),
    .data_en       (data_en),
    .done          (done)
);

// File: tb/cs_burst_splitter_tb.sv
module cs_burst_splitter_tb;
    localparam int CLK_MHZ = 100;
    localparam int ADDR_W  = 24;
    localparam int LEN_W   = 12;
    localparam int GAP_W   = 4;
    localparam int GUARD   = 4;
    localparam int CA_CYC  = 3;
    localparam int LAT_CYC = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic req_write = 1'b0;
    logic req_wrap = 1'b0;
    logic [1:0] cfg_temp_code = 2'b10;
    logic [GAP_W-1:0] cfg_min_gap = '0;
    logic cs_n, ca_valid, ca_write, ca_wrap, lat_long, data_en, done;
    logic [ADDR_W-1:0] ca_addr, data_addr;
    logic [LEN_W-1:0] ca_len;
    logic rwds_in = 1'b0;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    cs_burst_splitter #(
        .CLK_MHZ (CLK_MHZ), .ADDR_W (ADDR_W), .LEN_W (LEN_W), .GAP_W (GAP_W),
        .GUARD (GUARD), .CA_CYC (CA_CYC), .LAT_CYC (LAT_CYC)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .req_len (req_len), .req_write (req_write),
        .req_wrap (req_wrap), .cfg_temp_code (cfg_temp_code),
        .cfg_min_gap (cfg_min_gap), .cs_n (cs_n), .ca_valid (ca_valid),
        .ca_addr (ca_addr), .ca_len (ca_len), .ca_write (ca_write),
        .ca_wrap (ca_wrap), .rwds_in (rwds_in), .lat_long (lat_long),
        .data_en (data_en), .data_addr (data_addr), .done (done)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor state, sampled at the falling edge
    bit mon_on = 0;
    bit mon_prev = 1;
    bit mon_got_data;
    int mon_segs, mon_low, mon_hi, mon_max_low, mon_first_low, mon_min_gap;
    int mon_lat, mon_lat_bad, mon_words, mon_addr_bad, mon_ca_bad, mon_ca_len;
    int mon_ready_bad, mon_lflag_bad;
    int exp_lat, exp_len;
    logic [ADDR_W-1:0] exp_base;
    logic exp_wr, exp_wrap, exp_lflag;

    always @(negedge clk) begin
        if (mon_on) begin
            if (!cs_n) begin
                if (req_ready) mon_ready_bad++;
                if (mon_prev) begin
                    mon_segs++;
                    if (mon_segs > 1 && mon_hi < mon_min_gap) mon_min_gap = mon_hi;
                    mon_low = 0;
                    mon_lat = 0;
                    mon_ca_len = 0;
                    mon_got_data = 0;
                    if (!ca_valid || ca_addr != exp_base + ADDR_W'(mon_words) ||
                        int'(ca_len) != exp_len - mon_words ||
                        ca_write != exp_wr || ca_wrap != exp_wrap) mon_ca_bad++;
                end
                mon_low++;
                if (ca_valid) mon_ca_len++;
                if (!ca_valid && !data_en) mon_lat++;
                if (data_en) begin
                    if (!mon_got_data) begin
                        if (mon_lat != exp_lat || mon_ca_len != CA_CYC) mon_lat_bad++;
                        if (lat_long != exp_lflag) mon_lflag_bad++;
                        mon_got_data = 1;
                    end
                    if (data_addr != exp_base + ADDR_W'(mon_words)) mon_addr_bad++;
                    mon_words++;
                end
            end else begin
                if (!mon_prev) begin
                    if (mon_low > mon_max_low) mon_max_low = mon_low;
                    if (mon_segs == 1) mon_first_low = mon_low;
                    mon_hi = 0;
                end
                mon_hi++;
            end
            mon_prev = cs_n;
        end
    end

    task automatic run_burst(input string name, input int addr, input int len,
                             input bit wr, input bit wrap, input logic [1:0] code,
                             input int gap, input bit strobe);
        int budget, w, segs, fit, cyc;
        bit seen_done;
        budget = ((code == 2'b01) ? 4 * CLK_MHZ : CLK_MHZ) - GUARD;
        exp_lat = strobe ? 2 * LAT_CYC : LAT_CYC;
        w = budget - CA_CYC - exp_lat;
        segs = (len + w - 1) / w;
        fit = (len < w) ? len : w;
        @(negedge clk);
        exp_base = ADDR_W'(addr); exp_len = len; exp_wr = wr; exp_wrap = wrap;
        exp_lflag = strobe;
        mon_segs = 0; mon_low = 0; mon_hi = 0; mon_max_low = 0; mon_first_low = 0;
        mon_min_gap = 999; mon_lat_bad = 0; mon_words = 0; mon_addr_bad = 0;
        mon_ca_bad = 0; mon_ready_bad = 0; mon_lflag_bad = 0; mon_prev = 1;
        mon_on = 1;
        rwds_in = strobe;
        req_addr = ADDR_W'(addr); req_len = LEN_W'(len); req_write = wr;
        req_wrap = wrap; cfg_temp_code = code; cfg_min_gap = GAP_W'(gap);
        check({name, " R1 ready before request"}, int'(req_ready), 1);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cfg_temp_code = ~code;
        cfg_min_gap = '0;
        seen_done = 0;
        cyc = 0;
        while (!seen_done && cyc < 20000) begin
            if (done) begin
                seen_done = 1;
                check({name, " R9 cs_n high at done"}, int'(cs_n), 1);
            end else begin
                @(negedge clk);
                cyc++;
            end
        end
        check({name, " R9 done seen"}, int'(seen_done), 1);
        @(negedge clk);
        check({name, " R9 done is one pulse"}, int'(done), 0);
        mon_on = 0;
        check({name, " R6 word count"}, mon_words, len);
        check({name, " R6 data address errors"}, mon_addr_bad, 0);
        check({name, " R3 segment count"}, mon_segs, segs);
        check({name, " R1 ready low while busy"}, mon_ready_bad, 0);
        if (len > 0) begin
            check({name, " R2 first segment low time"}, mon_first_low, CA_CYC + exp_lat + fit);
            check({name, " R2 low time bound"}, int'(mon_max_low <= budget), 1);
            check({name, " R5 continuation fields"}, mon_ca_bad, 0);
            check({name, " R7 R8 command and latency length"}, mon_lat_bad, 0);
            check({name, " R8 long latency flag"}, mon_lflag_bad, 0);
        end
        if (segs > 1) begin
            check({name, " R4 minimum gap"}, mon_min_gap, (gap == 0) ? 1 : gap);
        end
    endtask

    task automatic test_reset();
        check("R10 cs_n after reset", int'(cs_n), 1);
        check("R10 ready after reset", int'(req_ready), 1);
        check("R10 data_en after reset", int'(data_en), 0);
        check("R10 done after reset", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        run_burst("short write",      16, 10,  1'b1, 1'b0, 2'b10, 2,  1'b0);
        run_burst("split read",       100, 200, 1'b0, 1'b1, 2'b10, 5,  1'b1);
        run_burst("cool code",        0,  500, 1'b1, 1'b0, 2'b01, 3,  1'b0);
        run_burst("code 00",          40, 100, 1'b0, 1'b0, 2'b00, 4,  1'b0);
        run_burst("code 11",          40, 100, 1'b1, 1'b1, 2'b11, 7,  1'b1);
        run_burst("zero gap",         8,  180, 1'b0, 1'b0, 2'b10, 0,  1'b0);
        run_burst("exact fit",        0,  87,  1'b1, 1'b0, 2'b10, 1,  1'b0);
        run_burst("fit plus one",     0,  88,  1'b1, 1'b0, 2'b10, 15, 1'b0);
        run_burst("zero length R9",   5,  0,   1'b0, 1'b0, 2'b10, 1,  1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule